// File: doc/BRIEF.md
# 1-Wire Bus Passive Monitor

This block listens to one open-drain 1-Wire data line and turns the activity on it into single-cycle event pulses. It takes no part in the bus. The line is sampled by the system clock. Every timing decision uses one unit T, given as a parameter in clock cycles, and each measurement starts from the most recent line edge. From these measurements the block finds reset pulses, reads the presence answer that follows a reset, and recovers data bits from time slots. It packs the bits into bytes, least significant bit first. The first byte after each reset is sorted into a ROM-layer command code.

The outputs follow a stream style. Each `*_valid` pulse lasts exactly one cycle, and it qualifies the value outputs that belong to it. The value outputs keep their last value until the next pulse. The block has no ready input, because a bus that is only watched cannot be stalled. A consumer must accept every pulse in the cycle it appears, or the event is lost.

Top module: `onewire_monitor`

## Requirements
- R1: After `rst_n` is released, every valid output is low, `bit_value`, `presence_seen` and `byte_value` are zero, and `cmd_code` is 0 (none).
- R2: A data bit is sampled T cycles after a falling edge that arrives while the line is idle. The bit is 1 if the line is high then and 0 if it is low, and `bit_valid` pulses once for each slot.
- R3: A 0 bit holds the monitor until the line returns high. Extra low time within the same slot produces no further bit events.
- R4: A low period longer than 8 T cycles, measured from the falling edge to the rising edge, pulses `reset_valid` at the rising edge. A low period shorter than this does not.
- R5: After each reset, the line is sampled 2.5 T cycles after the rising edge, and `presence_valid` pulses. `presence_seen` is 1 if the line was low at that point. A presence pulse produces no bit event.
- R6: Every eight bit events make one byte. The first bit received goes to bit 0. `byte_valid` pulses one cycle after the eighth `bit_valid`, and `byte_value` holds the assembled value.
- R7: A reset discards any partly assembled byte, so the next eight bits form a fresh byte.
- R8: The first byte after a reset pulses `cmd_valid` in the same cycle as `byte_valid`, with `cmd_code` set as follows: 0x33 or 0x0F gives 1 (read ROM), 0xCC gives 2 (skip ROM), 0x55 gives 3 (match ROM), 0xF0 gives 4 (search ROM), 0x3C gives 5 (overdrive skip ROM), 0x69 gives 6 (overdrive match ROM), and any other value gives 7 (unknown). A reset sets `cmd_code` to 0.
- R9: Bytes after the command byte, and bytes seen before the first reset, are reported only as bytes and never pulse `cmd_valid`.
- R10: The slot timer saturates. A line held low for any length of time beyond 8 T still gives exactly one reset.
- R11: In any one cycle, at most one of `reset_valid`, `presence_valid` and `bit_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| owr_in | input | 1 | Raw 1-Wire line level, asynchronous |
| reset_valid | output | 1 | Pulse: reset pulse detected |
| presence_valid | output | 1 | Pulse: presence sample taken |
| presence_seen | output | 1 | 1 when a device answered the last reset |
| bit_valid | output | 1 | Pulse: data bit recovered |
| bit_value | output | 1 | Last recovered bit |
| byte_valid | output | 1 | Pulse: byte assembled |
| byte_value | output | 8 | Last assembled byte |
| cmd_valid | output | 1 | Pulse: command byte classified |
| cmd_code | output | 3 | Command class of the first byte after reset |

## Verification
Some rules are checked by the bound checker on every cycle. These are that link events never overlap, that each byte follows a bit event, that a command comes only with a byte and always carries a real code, that presence follows a reset, and that two bit events are at least T cycles apart. Other behaviour can only be shown by the bench scenarios, which compare against expected values. These cover the sampling point at T, the 8 T reset threshold, the presence polarity, the order of bits within a byte, the discarding of a partial byte at reset, the full command table, and a reset far longer than the timer range.

// File: rtl/owm_pkg.sv
package owm_pkg;
  typedef enum logic [2:0] {
    CMD_NONE     = 3'd0,
    CMD_READ     = 3'd1,
    CMD_SKIP     = 3'd2,
    CMD_MATCH    = 3'd3,
    CMD_SEARCH   = 3'd4,
    CMD_OD_SKIP  = 3'd5,
    CMD_OD_MATCH = 3'd6,
    CMD_UNKNOWN  = 3'd7
  } rom_cmd_e;

  typedef enum logic [2:0] {
    LNK_IDLE,
    LNK_SAMPLE,
    LNK_LOW,
    LNK_PRES,
    LNK_PRES_END
  } lnk_state_e;

  function automatic rom_cmd_e classify_rom(input logic [7:0] b);
    case (b)
      8'h33, 8'h0F: classify_rom = CMD_READ;
      8'hCC:        classify_rom = CMD_SKIP;
      8'h55:        classify_rom = CMD_MATCH;
      8'hF0:        classify_rom = CMD_SEARCH;
      8'h3C:        classify_rom = CMD_OD_SKIP;
      8'h69:        classify_rom = CMD_OD_MATCH;
      default:      classify_rom = CMD_UNKNOWN;
    endcase
  endfunction
endpackage

// File: rtl/owm_sync.sv
module owm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic line_s,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              line_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain  <= '1;
      line_d <= 1'b1;
    end else begin
      chain  <= {chain[STAGES-2:0], raw};
      line_d <= chain[STAGES-1];
    end
  end

  assign line_s = chain[STAGES-1];
  assign fall   = line_d & ~line_s;
endmodule

// File: rtl/owm_link.sv
module owm_link
  import owm_pkg::*;
#(
  parameter int CLKS_PER_T = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_s,
  input  logic fall,
  output logic bit_valid,
  output logic bit_value,
  output logic reset_valid,
  output logic presence_valid,
  output logic presence_seen
);
  localparam int TW = $clog2(8 * CLKS_PER_T + 2) + 1;
  localparam logic [TW-1:0] SAMPLE_AT = TW'(CLKS_PER_T);
  localparam logic [TW-1:0] RESET_MIN = TW'(8 * CLKS_PER_T);
  localparam logic [TW-1:0] PRES_AT   = TW'((5 * CLKS_PER_T) / 2);
  localparam logic [TW-1:0] TMAX      = '1;

  lnk_state_e      state;
  logic [TW-1:0]   timer;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state          <= LNK_IDLE;
      timer          <= '0;
      bit_valid      <= 1'b0;
      bit_value      <= 1'b0;
      reset_valid    <= 1'b0;
      presence_valid <= 1'b0;
      presence_seen  <= 1'b0;
    end else begin
      bit_valid      <= 1'b0;
      reset_valid    <= 1'b0;
      presence_valid <= 1'b0;
      if (timer != TMAX) timer <= timer + 1'b1;
      unique case (state)
        LNK_IDLE: begin
          if (fall) begin
            timer <= TW'(1);
            state <= LNK_SAMPLE;
          end
        end
        LNK_SAMPLE: begin
          if (timer == SAMPLE_AT) begin
            bit_valid <= 1'b1;
            bit_value <= line_s;
            state     <= line_s ? LNK_IDLE : LNK_LOW;
          end
        end
        LNK_LOW: begin
          if (line_s) begin
            if (timer > RESET_MIN) begin
              reset_valid <= 1'b1;
              timer       <= TW'(1);
              state       <= LNK_PRES;
            end else begin
              state <= LNK_IDLE;
            end
          end
        end
        LNK_PRES: begin
          if (timer == PRES_AT) begin
            presence_valid <= 1'b1;
            presence_seen  <= ~line_s;
            state          <= line_s ? LNK_IDLE : LNK_PRES_END;
          end
        end
        LNK_PRES_END: begin
          if (line_s) state <= LNK_IDLE;
        end
        default: state <= LNK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/owm_assembler.sv
module owm_assembler
  import owm_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid,
  input  logic              bit_value,
  input  logic              reset_valid,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_value,
  output logic              cmd_valid,
  output rom_cmd_e          cmd_code
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] shreg;
  logic              armed;
  logic [BYTE_W-1:0] next_shreg;

  assign next_shreg = {bit_value, shreg[BYTE_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      shreg      <= '0;
      armed      <= 1'b0;
      byte_valid <= 1'b0;
      byte_value <= '0;
      cmd_valid  <= 1'b0;
      cmd_code   <= CMD_NONE;
    end else begin
      byte_valid <= 1'b0;
      cmd_valid  <= 1'b0;
      if (reset_valid) begin
        cnt      <= '0;
        shreg    <= '0;
        armed    <= 1'b1;
        cmd_code <= CMD_NONE;
      end else if (bit_valid) begin
        shreg <= next_shreg;
        if (cnt == LAST) begin
          cnt        <= '0;
          byte_valid <= 1'b1;
          byte_value <= next_shreg;
          if (armed) begin
            armed     <= 1'b0;
            cmd_valid <= 1'b1;
            cmd_code  <= classify_rom(next_shreg[7:0]);
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/onewire_monitor.sv
module onewire_monitor
  import owm_pkg::*;
#(
  parameter int CLKS_PER_T  = 3000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       owr_in,
  output logic       reset_valid,
  output logic       presence_valid,
  output logic       presence_seen,
  output logic       bit_valid,
  output logic       bit_value,
  output logic       byte_valid,
  output logic [7:0] byte_value,
  output logic       cmd_valid,
  output logic [2:0] cmd_code
);
  logic     line_s;
  logic     fall;
  rom_cmd_e code_e;

  owm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(owr_in), .line_s(line_s), .fall(fall)
  );

  owm_link #(.CLKS_PER_T(CLKS_PER_T)) u_link (
    .clk(clk), .rst_n(rst_n), .line_s(line_s), .fall(fall),
    .bit_valid(bit_valid), .bit_value(bit_value),
    .reset_valid(reset_valid), .presence_valid(presence_valid),
    .presence_seen(presence_seen)
  );

  owm_assembler #(.BYTE_W(8)) u_asm (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_value(bit_value),
    .reset_valid(reset_valid), .byte_valid(byte_valid),
    .byte_value(byte_value), .cmd_valid(cmd_valid), .cmd_code(code_e)
  );

  assign cmd_code = code_e;
endmodule

// File: rtl/onewire_monitor_chk.sv
module onewire_monitor_chk #(
  parameter int CLKS_PER_T = 3000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       reset_valid,
  input logic       presence_valid,
  input logic       bit_valid,
  input logic       byte_valid,
  input logic       cmd_valid,
  input logic [2:0] cmd_code
);
  logic        pending_pres;
  logic [31:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_pres <= 1'b0;
      gap          <= 32'hFFFF_FFFF;
    end else begin
      if (reset_valid)         pending_pres <= 1'b1;
      else if (presence_valid) pending_pres <= 1'b0;
      if (bit_valid)                 gap <= '0;
      else if (gap != 32'hFFFF_FFFF) gap <= gap + 1;
    end
  end

  AST_LINK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reset_valid, presence_valid, bit_valid})); // R11
  AST_BYTE_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(bit_valid)); // R6
  AST_CMD_WITH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> byte_valid); // R9
  AST_CMD_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_code != 3'd0)); // R8
  AST_PRES_NEEDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    presence_valid |-> pending_pres); // R5
  AST_BIT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> (gap >= 32'(CLKS_PER_T))); // R2
endmodule

bind onewire_monitor onewire_monitor_chk #(.CLKS_PER_T(CLKS_PER_T)) u_chk (
  .clk(clk), .rst_n(rst_n), .reset_valid(reset_valid),
  .presence_valid(presence_valid), .bit_valid(bit_valid),
  .byte_valid(byte_valid), .cmd_valid(cmd_valid), .cmd_code(cmd_code)
);

// File: tb/onewire_monitor_test.sv
`timescale 1ns/1ps
module onewire_monitor_test;
  localparam int T = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic owr = 1'b1;
  logic reset_valid, presence_valid, presence_seen, bit_valid, bit_value;
  logic byte_valid, cmd_valid;
  logic [7:0] byte_value;
  logic [2:0] cmd_code;

  int errors = 0, checks = 0;
  int n_rst = 0, n_pres = 0, n_bit = 0, n_byte = 0, n_cmd = 0;
  logic       l_bit = 1'b0, l_pres = 1'b0;
  logic [7:0] l_byte = '0;
  logic [2:0] l_cmd = '0;
  bit done = 0;

  always #5 clk = ~clk;

  onewire_monitor #(.CLKS_PER_T(T)) uut (
    .clk(clk), .rst_n(rst_n), .owr_in(owr),
    .reset_valid(reset_valid), .presence_valid(presence_valid),
    .presence_seen(presence_seen), .bit_valid(bit_valid),
    .bit_value(bit_value), .byte_valid(byte_valid), .byte_value(byte_value),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code)
  );

  always @(negedge clk) if (rst_n) begin
    if (reset_valid)    n_rst++;
    if (presence_valid) begin n_pres++; l_pres = presence_seen; end
    if (bit_valid)      begin n_bit++;  l_bit  = bit_value;     end
    if (byte_valid)     begin n_byte++; l_byte = byte_value;    end
    if (cmd_valid)      begin n_cmd++;  l_cmd  = cmd_code;      end
  end

  function automatic logic [2:0] want_cmd(input logic [7:0] b);
    if (b == 8'h33 || b == 8'h0F) return 3'd1;
    if (b == 8'hCC) return 3'd2;
    if (b == 8'h55) return 3'd3;
    if (b == 8'hF0) return 3'd4;
    if (b == 8'h3C) return 3'd5;
    if (b == 8'h69) return 3'd6;
    return 3'd7;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic low_pulse(input int n_low, input int n_high);
    owr = 1'b0; cyc(n_low);
    owr = 1'b1; cyc(n_high);
  endtask

  task automatic send_bit(input logic b);
    if (b) low_pulse(4, 4*T - 4);
    else   low_pulse(3*T, T);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
    cyc(4);
  endtask

  task automatic bus_reset(input bit answer);
    low_pulse(10*T, T);
    if (answer) low_pulse(4*T, 4*T);
    else        cyc(5*T);
  endtask

  task automatic cmd_case(input logic [7:0] v, input string req);
    int c0;
    bus_reset(1'b1);
    c0 = n_cmd;
    send_byte(v);
    check(n_cmd == c0 + 1, req, n_cmd - c0, 1);
    check(l_cmd == want_cmd(v), req, l_cmd, want_cmd(v));
    check(l_byte == v, req, l_byte, v);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int b0, r0, p0, y0, c0;
    logic [7:0] v;
    logic [7:0] table_v [8];
    void'($urandom(32'd20240611));
    cyc(5);
    @(negedge clk);
    // R1: state just after reset
    check(!reset_valid && !presence_valid && !bit_valid && !byte_valid && !cmd_valid,
          "R1", 1, 0);
    check(cmd_code == 3'd0 && byte_value == 8'd0 && !bit_value && !presence_seen,
          "R1", cmd_code, 0);
    rst_n = 1'b1;
    cyc(3*T);

    // R9: byte before any reset is not classified
    c0 = n_cmd; y0 = n_byte;
    send_byte(8'hCC);
    check(n_byte == y0 + 1 && l_byte == 8'hCC, "R9", l_byte, 8'hCC);
    check(n_cmd == c0, "R9", n_cmd - c0, 0);

    // R2: low just short of T reads 1, just past T reads 0
    b0 = n_bit;
    low_pulse(T - 2, 3*T);
    check(n_bit == b0 + 1 && l_bit == 1'b1, "R2", l_bit, 1);
    low_pulse(T + 2, 3*T);
    check(n_bit == b0 + 2 && l_bit == 1'b0, "R2", l_bit, 0);

    // R3: long low (6T) still one bit event
    b0 = n_bit;
    low_pulse(6*T, 2*T);
    check(n_bit == b0 + 1, "R3", n_bit - b0, 1);

    // R4: 8T-2 low is no reset, 8T+2 is one
    r0 = n_rst;
    low_pulse(8*T - 2, 4*T);
    check(n_rst == r0, "R4", n_rst - r0, 0);
    low_pulse(8*T + 2, 5*T);
    check(n_rst == r0 + 1, "R4", n_rst - r0, 1);

    // R5: presence answered / not answered, no bit from presence pulse
    p0 = n_pres; b0 = n_bit;
    bus_reset(1'b1);
    check(n_pres == p0 + 1 && l_pres == 1'b1, "R5", l_pres, 1);
    check(n_bit == b0 + 1, "R5", n_bit - b0, 1);
    bus_reset(1'b0);
    check(n_pres == p0 + 2 && l_pres == 1'b0, "R5", l_pres, 0);

    // R10: very long low well beyond timer range gives one reset
    r0 = n_rst;
    low_pulse(40*T, T);
    cyc(5*T);
    check(n_rst == r0 + 1, "R10", n_rst - r0, 1);

    // R7: partial byte dropped by reset
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    y0 = n_byte;
    bus_reset(1'b1);
    send_byte(8'hA6);
    check(n_byte == y0 + 1 && l_byte == 8'hA6, "R7", l_byte, 8'hA6);
    check(cmd_code == 3'd7, "R7", cmd_code, 7);
    bus_reset(1'b1);
    check(cmd_code == 3'd0, "R8", cmd_code, 0);

    // R8: full command table plus unknown
    table_v[0] = 8'h33; table_v[1] = 8'h0F; table_v[2] = 8'hCC; table_v[3] = 8'h55;
    table_v[4] = 8'hF0; table_v[5] = 8'h3C; table_v[6] = 8'h69; table_v[7] = 8'h00;
    for (int i = 0; i < 8; i++) cmd_case(table_v[i], "R8");

    // R6 / R9: random sessions, LSB-first bytes, only first byte classified
    for (int s = 0; s < 6; s++) begin
      v = 8'($urandom);
      cmd_case(v, "R8");
      for (int k = 0; k < 3; k++) begin
        v = 8'($urandom);
        c0 = n_cmd; y0 = n_byte;
        send_byte(v);
        check(n_byte == y0 + 1 && l_byte == v, "R6", l_byte, v);
        check(n_cmd == c0, "R9", n_cmd - c0, 0);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule